// File: doc/BRIEF.md
# Banked Frame Capture Store

This block captures one complete image frame from the converter side and holds it in a set of external synchronous memory banks until the host side asks for it. The sequencer opens a frame with a start marker. Every converter word marked valid after that marker is written at the next linear word position. The linear position is split into a bank select and an in-bank word address. When the last word of the frame (all rows times all columns, overscan columns included) has been written, the block raises a frame-ready flag and stops accepting data.

The stored frame stays untouched until the host pulses a request. The block then reads the memory back word by word and presents the words in write order on a valid/ready stream. A sequencer start marker that arrives while a frame is still waiting is dropped and flagged as an overrun. An end marker that arrives before the frame is full discards the partial frame.

Top module: `fcap_frame_store`

## Requirements
- R1: After reset, frame_ready, overrun and out_valid are 0 and no mem_ce bit is set.
- R2: A start marker (sof) while idle or capturing opens a capture at word 0. A converter word with adc_valid=1 is written (mem_we=1, mem_wdata=adc_data) only while capturing and not in a sof cycle. Words offered while idle, or in the sof cycle, produce mem_we=0.
- R3: The word at linear position L drives the one-hot mem_ce bit number L / 2^BANK_AW and mem_addr = L mod 2^BANK_AW. At most one mem_ce bit is ever set.
- R4: frame_ready is 0 in the cycle that writes word ROWS*COLS-1 and is 1 in the cycle after it.
- R5: An eof marker before the last word is written discards the capture. The block returns to idle with frame_ready at 0, and a later rd_req produces no out_valid and no memory access.
- R6: A sof while capturing restarts the capture at linear word 0.
- R7: While frame_ready is 1, a sof is ignored and sets overrun in the next cycle. overrun returns to 0 when a later sof is accepted.
- R8: A rd_req while frame_ready is 1 and no readout runs starts a readout. The words appear on out_data in write order. While out_valid=1 and out_ready=0, out_valid and out_data hold.
- R9: frame_ready returns to 0 in the cycle after the handshake of the last word, and no further words are presented.
- R10: While frame_ready is 1, offered converter words are not written, and the held frame reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Sequencer start-of-frame marker |
| eof | input | 1 | Sequencer end-of-frame marker |
| adc_valid | input | 1 | Converter word valid |
| adc_data | input | DATA_W | Converter word |
| rd_req | input | 1 | Host request to drain the stored frame |
| out_ready | input | 1 | Host accepts the presented word |
| out_valid | output | 1 | Readout word valid |
| out_data | output | DATA_W | Readout word |
| frame_ready | output | 1 | A complete frame is held |
| overrun | output | 1 | A start marker was dropped while a frame was held |
| mem_ce | output | NUM_BANKS | One-hot bank enable |
| mem_we | output | 1 | Write strobe, 0 means read |
| mem_addr | output | BANK_AW | Word address inside the bank |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after an enabled read |

## Verification
The hardest condition to reach is a held frame that is being hit from both sides at once. Converter words and a fresh start marker arrive while the frame waits, and the host later stalls readout across bank boundaries. The bench uses small geometry parameters so that one frame spans four banks. It fills a frame, then offers a marker and data while the frame is ready. It then drains the frame under a per-word stall mask, so that any overwrite, skipped word or repeated word shows up as a data mismatch.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPT,
        ST_FULL,
        ST_RD_ISSUE,
        ST_RD_CAP,
        ST_RD_HOLD
    } fcap_state_e;

endpackage

// File: rtl/fcap_bank_decode.sv
module fcap_bank_decode #(
    parameter int NUM_BANKS = 6,
    parameter int BANK_AW   = 20,
    parameter int BSEL_W    = 3,
    parameter int LIN_W     = BANK_AW + BSEL_W
) (
    input  logic                 en,
    input  logic [LIN_W-1:0]     lin_addr,
    output logic [NUM_BANKS-1:0] ce,
    output logic [BANK_AW-1:0]   addr
);

    logic [BSEL_W-1:0] bank_sel;

    assign bank_sel = lin_addr[LIN_W-1:BANK_AW];
    assign addr     = lin_addr[BANK_AW-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ce[b] = en && (bank_sel == BSEL_W'(b));
    end

endmodule

// File: rtl/fcap_seq_ctrl.sv
module fcap_seq_ctrl
    import fcap_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int LIN_W       = 23,
    parameter int FRAME_WORDS = 2048 * 2148
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              eof,
    input  logic              adc_valid,
    input  logic              rd_req,
    input  logic              out_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [LIN_W-1:0]  lin_addr,
    output logic              mem_en,
    output logic              mem_we,
    output logic              frame_ready,
    output logic              overrun,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [LIN_W-1:0] LAST_WORD = LIN_W'(FRAME_WORDS - 1);

    typedef struct packed {
        fcap_state_e       st;
        logic [LIN_W-1:0]  ptr;
        logic              ready;
        logic              ovr;
        logic              ovalid;
        logic [DATA_W-1:0] odata;
    } regs_t;

    localparam regs_t RST_VAL = '{
        st:     ST_IDLE,
        ptr:    '0,
        ready:  1'b0,
        ovr:    1'b0,
        ovalid: 1'b0,
        odata:  '0
    };

    regs_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        mem_en = 1'b0;
        mem_we = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (sof) begin
                    r_d.st  = ST_CAPT;
                    r_d.ptr = '0;
                    r_d.ovr = 1'b0;
                end
            end
            ST_CAPT: begin
                if (sof) begin
                    r_d.ptr = '0;
                    r_d.ovr = 1'b0;
                end else if (adc_valid) begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                    if (r_q.ptr == LAST_WORD) begin
                        r_d.st    = ST_FULL;
                        r_d.ready = 1'b1;
                        r_d.ptr   = '0;
                    end else begin
                        r_d.ptr = r_q.ptr + 1'b1;
                        if (eof) begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end else if (eof) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_FULL: begin
                if (rd_req) begin
                    r_d.st  = ST_RD_ISSUE;
                    r_d.ptr = '0;
                end
            end
            ST_RD_ISSUE: begin
                mem_en = 1'b1;
                r_d.st = ST_RD_CAP;
            end
            ST_RD_CAP: begin
                r_d.odata  = mem_rdata;
                r_d.ovalid = 1'b1;
                r_d.st     = ST_RD_HOLD;
            end
            ST_RD_HOLD: begin
                if (out_ready) begin
                    r_d.ovalid = 1'b0;
                    if (r_q.ptr == LAST_WORD) begin
                        r_d.ready = 1'b0;
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.ptr = r_q.ptr + 1'b1;
                        r_d.st  = ST_RD_ISSUE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (sof && r_q.ready) begin
            r_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign lin_addr    = r_q.ptr;
    assign frame_ready = r_q.ready;
    assign overrun     = r_q.ovr;
    assign out_valid   = r_q.ovalid;
    assign out_data    = r_q.odata;

endmodule

// File: rtl/fcap_frame_store.sv
module fcap_frame_store #(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 6,
    parameter int BANK_AW   = 20,
    parameter int ROWS      = 2048,
    parameter int COLS      = 2148
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sof,
    input  logic                 eof,
    input  logic                 adc_valid,
    input  logic [DATA_W-1:0]    adc_data,
    input  logic                 rd_req,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data,
    output logic                 frame_ready,
    output logic                 overrun,
    output logic [NUM_BANKS-1:0] mem_ce,
    output logic                 mem_we,
    output logic [BANK_AW-1:0]   mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata
);

    localparam int FRAME_WORDS = ROWS * COLS;
    localparam int BSEL_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int LIN_W       = BANK_AW + BSEL_W;

    logic [LIN_W-1:0] lin_addr;
    logic             mem_en;

    fcap_seq_ctrl #(
        .DATA_W      (DATA_W),
        .LIN_W       (LIN_W),
        .FRAME_WORDS (FRAME_WORDS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof         (sof),
        .eof         (eof),
        .adc_valid   (adc_valid),
        .rd_req      (rd_req),
        .out_ready   (out_ready),
        .mem_rdata   (mem_rdata),
        .lin_addr    (lin_addr),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .frame_ready (frame_ready),
        .overrun     (overrun),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );

    fcap_bank_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_AW   (BANK_AW),
        .BSEL_W    (BSEL_W),
        .LIN_W     (LIN_W)
    ) u_decode (
        .en       (mem_en),
        .lin_addr (lin_addr),
        .ce       (mem_ce),
        .addr     (mem_addr)
    );

    assign mem_wdata = adc_data;

endmodule

// File: rtl/fcap_checker.sv
module fcap_checker #(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sof,
    input logic                 out_ready,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    out_data,
    input logic                 frame_ready,
    input logic                 overrun,
    input logic [NUM_BANKS-1:0] mem_ce,
    input logic                 mem_we
);

    AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_ce)); // R3

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_ce != '0)); // R3

    AST_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready |-> !mem_we); // R10

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ready && sof) |=> overrun); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_VALID_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> frame_ready); // R9

endmodule

bind fcap_frame_store fcap_checker #(
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
) u_fcap_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof         (sof),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .frame_ready (frame_ready),
    .overrun     (overrun),
    .mem_ce      (mem_ce),
    .mem_we      (mem_we)
);

// File: tb/fcap_frame_store_bench.sv
module fcap_frame_store_bench;

    localparam int DATA_W    = 16;
    localparam int NUM_BANKS = 6;
    localparam int BANK_AW   = 2;
    localparam int ROWS      = 3;
    localparam int COLS      = 5;
    localparam int NWORDS    = ROWS * COLS;
    localparam int BDEPTH    = 1 << BANK_AW;

    // each vector: {seed, gap/stall mask}
    localparam logic [23:0] VECS [4] = '{
        {16'hA000, 8'h00},
        {16'h1234, 8'h55},
        {16'hFFF0, 8'hFF},
        {16'h0F0F, 8'h81}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sof = 1'b0, eof = 1'b0, adc_valid = 1'b0;
    logic [DATA_W-1:0]    adc_data = '0;
    logic                 rd_req = 1'b0, out_ready = 1'b0;
    logic                 out_valid, frame_ready, overrun, mem_we;
    logic [DATA_W-1:0]    out_data, mem_wdata;
    logic [DATA_W-1:0]    mem_rdata = '0;
    logic [NUM_BANKS-1:0] mem_ce;
    logic [BANK_AW-1:0]   mem_addr;

    int checks = 0;
    int failures = 0;

    logic [DATA_W-1:0] mem [NUM_BANKS][BDEPTH];

    always #10 clk = ~clk;

    fcap_frame_store #(
        .DATA_W (DATA_W), .NUM_BANKS (NUM_BANKS), .BANK_AW (BANK_AW),
        .ROWS (ROWS), .COLS (COLS)
    ) u_fcap_frame_store (
        .clk (clk), .rst_n (rst_n), .sof (sof), .eof (eof),
        .adc_valid (adc_valid), .adc_data (adc_data),
        .rd_req (rd_req), .out_ready (out_ready),
        .out_valid (out_valid), .out_data (out_data),
        .frame_ready (frame_ready), .overrun (overrun),
        .mem_ce (mem_ce), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (mem_ce[b]) begin
                if (mem_we) mem[b][mem_addr] <= mem_wdata;
                else        mem_rdata <= mem[b][mem_addr];
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] word_of(input logic [15:0] seed, input int i);
        return seed + DATA_W'(i) * 16'h0123;
    endfunction

    task automatic cap_frame(input logic [15:0] seed, input logic [7:0] gaps);
        @(negedge clk);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        chk({31'd0, overrun}, 32'd0, "R7 overrun cleared by accepted sof");
        for (int i = 0; i < NWORDS; i++) begin
            if (gaps[i % 8]) begin
                adc_valid = 1'b0;
                @(negedge clk);
            end
            adc_valid = 1'b1;
            adc_data  = word_of(seed, i);
            #1;
            chk({31'd0, mem_we}, 32'd1, "R2 write strobe");
            chk({26'd0, mem_ce}, 32'd1 << (i / BDEPTH), "R3 bank select");
            chk({30'd0, mem_addr}, 32'(i % BDEPTH), "R3 in-bank address");
            if (i == NWORDS - 1)
                chk({31'd0, frame_ready}, 32'd0, "R4 not ready during last write");
            @(negedge clk);
        end
        adc_valid = 1'b0;
        chk({31'd0, frame_ready}, 32'd1, "R4 ready after last write");
    endtask

    task automatic read_frame(input logic [15:0] seed, input logic [7:0] stalls);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < NWORDS; i++) begin
            for (int t = 0; t < 10 && !out_valid; t++) @(negedge clk);
            chk({31'd0, out_valid}, 32'd1, "R8 word presented");
            chk({16'd0, out_data}, {16'd0, word_of(seed, i)}, "R8 word order");
            if (stalls[i % 8]) begin
                @(negedge clk);
                chk({15'd0, out_valid, out_data}, {15'd0, 1'b1, word_of(seed, i)},
                    "R8 hold under stall");
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        chk({31'd0, frame_ready}, 32'd0, "R9 ready cleared after last word");
        repeat (4) @(negedge clk);
        chk({31'd0, out_valid}, 32'd0, "R9 no extra words");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({29'd0, frame_ready, overrun, out_valid}, 32'd0, "R1 reset flags");
        chk({26'd0, mem_ce}, 32'd0, "R1 reset no bank enable");

        adc_valid = 1'b1; adc_data = 16'hBEEF; #1;
        chk({31'd0, mem_we}, 32'd0, "R2 idle word not written");
        @(negedge clk);
        sof = 1'b1; #1;
        chk({31'd0, mem_we}, 32'd0, "R2 sof-cycle word not written");
        @(negedge clk);
        sof = 1'b0;
        repeat (4) @(negedge clk);
        adc_valid = 1'b0; eof = 1'b1;
        @(negedge clk);
        eof = 1'b0;
        chk({31'd0, frame_ready}, 32'd0, "R5 partial frame not ready");
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        for (int t = 0; t < 6; t++) begin
            chk({25'd0, out_valid, mem_ce}, 32'd0, "R5 request ignored after discard");
            @(negedge clk);
        end

        // R6: partial capture then restart
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0; adc_valid = 1'b1; adc_data = 16'h7777;
        repeat (3) @(negedge clk);
        adc_valid = 1'b0;
        cap_frame(16'h3C00, 8'h02);
        read_frame(16'h3C00, 8'h00);  // R6 restarted frame reads from word 0

        for (int v = 0; v < 4; v++) begin
            cap_frame(VECS[v][23:8], VECS[v][7:0]);
            read_frame(VECS[v][23:8], VECS[v][7:0]);
        end

        // R7 / R10: disturbance while frame held
        cap_frame(16'h5A5A, 8'h10);
        sof = 1'b1; adc_valid = 1'b1; adc_data = 16'hDEAD; #1;
        chk({31'd0, mem_we}, 32'd0, "R10 no write while held");
        @(negedge clk);
        sof = 1'b0; #1;
        chk({31'd0, overrun}, 32'd1, "R7 overrun raised");
        chk({31'd0, mem_we}, 32'd0, "R10 no write while held");
        @(negedge clk);
        adc_valid = 1'b0;
        chk({31'd0, frame_ready}, 32'd1, "R7 frame still held");
        read_frame(16'h5A5A, 8'h24);  // R10 held data intact
        cap_frame(16'h0001, 8'h00);
        read_frame(16'h0001, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule